// File: doc/BRIEF.md
# Eight-Channel Serial DAC Command Receiver

This block is the device side of a serial control port for an eight-channel, 12-bit DAC. A host shifts 16-bit command words into it, most significant bit first, one bit per rising edge of a serial clock. A rising edge on a strobe line closes the word. Each accepted word has a 4-bit address code and a 12-bit data field. The block uses them to update eight input buffers, two control registers, or every channel at once.

The outputs are double-buffered. Writing a buffer does not change the analog-side value of a channel. While the active-low load input is held low, every input buffer is copied into its output register on each clock. On that copy the block can turn two's-complement codes into offset binary. A channel can be switched off by a global power-down bit or by the power-down bit of its pair. A channel that is off reads zero, and its output register keeps the stored value.

All inputs are synchronous to `clk_i`. The serial clock and the strobe are edge-detected in that clock domain. They must therefore stay at each level for at least one `clk_i` period.

Top module: `dac_cmd_rx`

## Requirements
- R1: After the asynchronous reset `rst_ni`, all channel outputs, power-down flags and both control registers read zero.
- R2: A command word holds the address code in bits 15..12 and the data in bits 11..0, and it arrives MSB first. Codes 0..7 write the input buffer of channel 0..7. The output of that channel does not change until a load.
- R3: While `load_ni` is low, each channel's output register takes its input buffer value on every clock. While `load_ni` is high, the output registers hold their values.
- R4: Codes 12, 13, 14 and 15 each address one channel pair: (0,1), (2,3), (4,5) and (6,7) in that order. The data goes to the even channel's buffer and its bitwise complement goes to the odd channel's buffer.
- R5: Code 8 stores data bits 4..0 into control register 0, and code 9 stores data bits 7..0 into control register 1. Both registers are visible on `ctrl0_o` and `ctrl1_o`.
- R6: Code 10 (preset) sets every input buffer and every output register to 0x800 at once, without a load, and leaves both control registers unchanged.
- R7: Code 11 changes no buffer, no output and no control register.
- R8: A word is accepted only when the strobe rises after exactly 16 serial clock edges. With 15 or 17 edges the word is discarded. Every strobe rise restarts the bit count.
- R9: When control register 0 bit 0 is 1 (two's-complement mode), a load inverts bit 11 of the value copied into each output register.
- R10: When control register 0 bit 4 is 1, all eight power-down flags are 1 and all channel outputs read zero.
- R11: Control register 1 bit 4+p powers down pair p, which is channels 2p and 2p+1. The flags of those two channels read 1 and their outputs read zero.
- R12: Power-down does not alter the output registers. When power-down is removed, the channel shows its previous value again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock; data is sampled on its rising edge |
| sdat_i | input | 1 | Serial data, MSB first |
| sstr_i | input | 1 | Frame strobe; its rising edge ends a word |
| load_ni | input | 1 | Active-low load of the input buffers into the output registers |
| dac_o | output | 96 | Channel outputs; channel k occupies bits 12k+11..12k |
| pd_o | output | 8 | Per-channel power-down flag |
| ctrl0_o | output | 5 | Control register 0 (power down, data-out enable, reference, input mode) |
| ctrl1_o | output | 8 | Control register 1 (pair power downs in 7..4, pair speeds in 3..0) |

## Verification
A wrong bit count or a mis-shifted word shows up at the ports in one of two ways. A register that should have been written keeps its old value, or the wrong channel, pair half or control field changes. The control registers show this in the first clock after the strobe. A channel shows it after the next load. A buffer corrupted behind the output stage stays hidden until the next load. For that reason the bench does a load after every write and compares all eight channels each time. A power-down or inversion fault shows on `dac_o` and `pd_o` in the same cycle that the control bit changes, or in the cycle after the load.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;
  localparam int NCH   = 8;
  localparam int DW    = 12;
  localparam int AW    = 4;
  localparam int FW    = AW + DW;
  localparam int CW    = $clog2(FW + 2);
  localparam int NPAIR = NCH / 2;
  localparam int C0W   = 5;
  localparam int C1W   = 2 * NPAIR;

  localparam logic [AW-1:0] A_CTRL0  = 4'd8;
  localparam logic [AW-1:0] A_CTRL1  = 4'd9;
  localparam logic [AW-1:0] A_PRESET = 4'd10;
  localparam logic [AW-1:0] A_PAIR   = 4'd12;

  localparam int C0_TC = 0;
  localparam int C0_PD = 4;

  localparam logic [DW-1:0] MID = 12'h800;
endpackage

// File: rtl/dac_rx_shift.sv
module dac_rx_shift
  import dac_cmd_pkg::*;
#(
  parameter int FW_P = FW,
  parameter int CW_P = CW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sclk_i,
  input  logic            sdat_i,
  input  logic            sstr_i,
  output logic [FW_P-1:0] frame_o,
  output logic            vld_o
);
  localparam logic [CW_P-1:0] CMAX = CW_P'(FW_P + 1);

  logic            sclk_q, sstr_q;
  logic [CW_P-1:0] cnt_q;
  logic [FW_P-1:0] sh_q;
  logic            sclk_rise, str_rise;

  assign sclk_rise = sclk_i & ~sclk_q;
  assign str_rise  = sstr_i & ~sstr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      sstr_q <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
    end else begin
      sclk_q <= sclk_i;
      sstr_q <= sstr_i;
      if (str_rise) begin
        cnt_q <= '0;
      end else if (sclk_rise) begin
        sh_q <= {sh_q[FW_P-2:0], sdat_i};
        // saturate so an overlong word never wraps back to a valid count
        if (cnt_q != CMAX) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign vld_o   = str_rise && (cnt_q == CW_P'(FW_P));
  assign frame_o = sh_q;
endmodule

// File: rtl/dac_regs.sv
module dac_regs
  import dac_cmd_pkg::*;
#(
  parameter int NCH_P = NCH,
  parameter int DW_P  = DW,
  parameter int AW_P  = AW,
  parameter int C0W_P = C0W,
  parameter int C1W_P = C1W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  vld_i,
  input  logic [AW_P+DW_P-1:0]  frame_i,
  output logic [NCH_P*DW_P-1:0] buf_o,
  output logic [C0W_P-1:0]      ctrl0_o,
  output logic [C1W_P-1:0]      ctrl1_o,
  output logic                  preset_o
);
  localparam int IW = $clog2(NCH_P);

  logic [AW_P-1:0]  addr;
  logic [DW_P-1:0]  data;
  logic [DW_P-1:0]  buf_q [NCH_P];
  logic [C0W_P-1:0] ctrl0_q;
  logic [C1W_P-1:0] ctrl1_q;

  assign addr     = frame_i[AW_P+DW_P-1 -: AW_P];
  assign data     = frame_i[DW_P-1:0];
  assign preset_o = vld_i && (addr == A_PRESET);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NCH_P; i++) buf_q[i] <= '0;
      ctrl0_q <= '0;
      ctrl1_q <= '0;
    end else if (vld_i) begin
      if (addr < AW_P'(NCH_P)) begin
        buf_q[addr[IW-1:0]] <= data;
      end else if (addr == A_CTRL0) begin
        ctrl0_q <= data[C0W_P-1:0];
      end else if (addr == A_CTRL1) begin
        ctrl1_q <= data[C1W_P-1:0];
      end else if (addr == A_PRESET) begin
        for (int i = 0; i < NCH_P; i++) buf_q[i] <= MID;
      end else if (addr >= A_PAIR) begin
        buf_q[{addr[IW-2:0], 1'b0}] <= data;
        buf_q[{addr[IW-2:0], 1'b1}] <= ~data;
      end
    end
  end

  for (genvar i = 0; i < NCH_P; i++) begin : g_flat
    assign buf_o[i*DW_P +: DW_P] = buf_q[i];
  end

  assign ctrl0_o = ctrl0_q;
  assign ctrl1_o = ctrl1_q;
endmodule

// File: rtl/dac_out.sv
module dac_out
  import dac_cmd_pkg::*;
#(
  parameter int NCH_P = NCH,
  parameter int DW_P  = DW,
  parameter int C0W_P = C0W,
  parameter int C1W_P = C1W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_ni,
  input  logic                  preset_i,
  input  logic [NCH_P*DW_P-1:0] buf_i,
  input  logic [C0W_P-1:0]      ctrl0_i,
  input  logic [C1W_P-1:0]      ctrl1_i,
  output logic [NCH_P*DW_P-1:0] out_o,
  output logic [NCH_P*DW_P-1:0] dac_o,
  output logic [NCH_P-1:0]      pd_o
);
  localparam int NP = NCH_P / 2;

  logic [DW_P-1:0] conv;
  assign conv = {ctrl0_i[C0_TC], {(DW_P-1){1'b0}}};

  for (genvar i = 0; i < NCH_P; i++) begin : g_ch
    logic [DW_P-1:0] out_q;
    logic            pd;

    assign pd = ctrl0_i[C0_PD] | ctrl1_i[NP + i/2];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       out_q <= '0;
      else if (preset_i) out_q <= MID;
      else if (!load_ni) out_q <= buf_i[i*DW_P +: DW_P] ^ conv;
    end

    assign out_o[i*DW_P +: DW_P] = out_q;
    assign dac_o[i*DW_P +: DW_P] = pd ? '0 : out_q;
    assign pd_o[i]               = pd;
  end
endmodule

// File: rtl/dac_cmd_rx.sv
module dac_cmd_rx
  import dac_cmd_pkg::*;
#(
  parameter int NCH_P = NCH,
  parameter int DW_P  = DW,
  parameter int AW_P  = AW,
  parameter int C0W_P = C0W,
  parameter int C1W_P = C1W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sclk_i,
  input  logic                  sdat_i,
  input  logic                  sstr_i,
  input  logic                  load_ni,
  output logic [NCH_P*DW_P-1:0] dac_o,
  output logic [NCH_P-1:0]      pd_o,
  output logic [C0W_P-1:0]      ctrl0_o,
  output logic [C1W_P-1:0]      ctrl1_o
);
  localparam int FWL = AW_P + DW_P;
  localparam int CWL = $clog2(FWL + 2);

  logic [FWL-1:0]        frame;
  logic                  frm_vld;
  logic                  preset;
  logic [NCH_P*DW_P-1:0] buf_v;
  logic [NCH_P*DW_P-1:0] out_v;

  dac_rx_shift #(.FW_P(FWL), .CW_P(CWL)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sclk_i (sclk_i),
    .sdat_i (sdat_i),
    .sstr_i (sstr_i),
    .frame_o(frame),
    .vld_o  (frm_vld)
  );

  dac_regs #(.NCH_P(NCH_P), .DW_P(DW_P), .AW_P(AW_P), .C0W_P(C0W_P), .C1W_P(C1W_P)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .vld_i   (frm_vld),
    .frame_i (frame),
    .buf_o   (buf_v),
    .ctrl0_o (ctrl0_o),
    .ctrl1_o (ctrl1_o),
    .preset_o(preset)
  );

  dac_out #(.NCH_P(NCH_P), .DW_P(DW_P), .C0W_P(C0W_P), .C1W_P(C1W_P)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_ni (load_ni),
    .preset_i(preset),
    .buf_i   (buf_v),
    .ctrl0_i (ctrl0_o),
    .ctrl1_i (ctrl1_o),
    .out_o   (out_v),
    .dac_o   (dac_o),
    .pd_o    (pd_o)
  );
endmodule

// File: rtl/dac_cmd_rx_chk.sv
module dac_cmd_rx_chk
  import dac_cmd_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_ni,
  input logic              vld_i,
  input logic              preset_i,
  input logic [CW-1:0]     cnt_i,
  input logic [NCH*DW-1:0] out_i,
  input logic [NCH*DW-1:0] dac_o,
  input logic [NCH-1:0]    pd_o,
  input logic [C0W-1:0]    ctrl0_o,
  input logic [C1W-1:0]    ctrl1_o
);
  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && !preset_i) |=> $stable(out_i));

  assert_preset_mid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    preset_i |=> (out_i == {NCH{MID}}));

  assert_ctrl_only_on_word_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> ($stable(ctrl0_o) && $stable(ctrl1_o)));

  assert_cnt_saturates_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= CW'(FW + 1));

  assert_global_pd_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl0_o[C0_PD] |-> (&pd_o && dac_o == '0));

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    assert_pair_pd_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ctrl1_o[NPAIR + p] |-> (pd_o[2*p] && pd_o[2*p+1] &&
                              dac_o[2*p*DW +: 2*DW] == '0));
  end
endmodule

bind dac_cmd_rx dac_cmd_rx_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .load_ni (load_ni),
  .vld_i   (frm_vld),
  .preset_i(preset),
  .cnt_i   (u_rx.cnt_q),
  .out_i   (out_v),
  .dac_o   (dac_o),
  .pd_o    (pd_o),
  .ctrl0_o (ctrl0_o),
  .ctrl1_o (ctrl1_o)
);

// File: tb/dac_cmd_rx_tb.sv
module dac_cmd_rx_tb;
  localparam time PERIOD = 10ns;
  localparam int  NCH = 8;
  localparam int  DW  = 12;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              sclk_i = 1'b0, sdat_i = 1'b0, sstr_i = 1'b0, load_ni = 1'b1;
  logic [NCH*DW-1:0] dac_o;
  logic [NCH-1:0]    pd_o;
  logic [4:0]        ctrl0_o;
  logic [7:0]        ctrl1_o;

  int checks = 0;
  int errors = 0;

  logic [DW-1:0] bufm [NCH];
  logic [DW-1:0] outm [NCH];
  logic [4:0]    c0m;
  logic [7:0]    c1m;

  always #(PERIOD/2) clk_i = ~clk_i;

  dac_cmd_rx u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sclk_i(sclk_i), .sdat_i(sdat_i),
    .sstr_i(sstr_i), .load_ni(load_ni), .dac_o(dac_o), .pd_o(pd_o),
    .ctrl0_o(ctrl0_o), .ctrl1_o(ctrl1_o)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  function automatic logic model_pd(input int k);
    return c0m[4] | c1m[4 + k/2];
  endfunction

  task automatic check_all(input string req);
    for (int k = 0; k < NCH; k++) begin
      chk(req, $sformatf("ch%0d", k), 32'(dac_o[k*DW +: DW]), model_pd(k) ? 32'd0 : 32'(outm[k]));
      chk(req, $sformatf("pd%0d", k), 32'(pd_o[k]), 32'(model_pd(k)));
    end
    chk(req, "ctrl0", 32'(ctrl0_o), 32'(c0m));
    chk(req, "ctrl1", 32'(ctrl1_o), 32'(c1m));
  endtask

  // nbits: 16 normal, fewer drops leading bits, more prepends zeros
  task automatic send(input logic [3:0] a, input logic [11:0] d, input int nbits);
    logic [15:0] w;
    w = {a, d};
    for (int i = nbits - 1; i >= 0; i--) begin
      @(negedge clk_i);
      sdat_i = (i < 16) ? w[i] : 1'b0;
      cyc(2); sclk_i = 1'b1;
      cyc(2); sclk_i = 1'b0;
    end
    cyc(1); sstr_i = 1'b1;
    cyc(2); sstr_i = 1'b0;
    cyc(2);
    if (nbits == 16) begin
      if (a < 4'd8) bufm[a[2:0]] = d;
      else if (a == 4'd8) c0m = d[4:0];
      else if (a == 4'd9) c1m = d[7:0];
      else if (a == 4'd10) begin
        for (int k = 0; k < NCH; k++) begin bufm[k] = 12'h800; outm[k] = 12'h800; end
      end else if (a >= 4'd12) begin
        bufm[{a[1:0], 1'b0}] = d;
        bufm[{a[1:0], 1'b1}] = ~d;
      end
    end
  endtask

  task automatic load();
    @(negedge clk_i); load_ni = 1'b0;
    cyc(2); load_ni = 1'b1;
    cyc(2);
    for (int k = 0; k < NCH; k++) outm[k] = bufm[k] ^ (c0m[0] ? 12'h800 : 12'h000);
  endtask

  task automatic t_reset();
    check_all("R1");
  endtask

  task automatic t_write();
    send(4'd3, 12'hABC, 16);
    check_all("R2");
    load();
    check_all("R3");
    for (int k = 0; k < NCH; k++) send(4'(k), 12'(12'h100 + k * 12'h111), 16);
    check_all("R2");
    load();
    check_all("R3");
  endtask

  task automatic t_pair();
    send(4'd13, 12'h35A, 16);
    send(4'd15, 12'h0F0, 16);
    load();
    chk("R4", "ch2", 32'(dac_o[2*DW +: DW]), 32'h35A);
    chk("R4", "ch3", 32'(dac_o[3*DW +: DW]), 32'hCA5);
    chk("R4", "ch7", 32'(dac_o[7*DW +: DW]), 32'hF0F);
    check_all("R4");
  endtask

  task automatic t_ctrl();
    send(4'd8, 12'hFEA, 16);
    chk("R5", "ctrl0", 32'(ctrl0_o), 32'h0A);
    send(4'd9, 12'hF0F, 16);
    chk("R5", "ctrl1", 32'(ctrl1_o), 32'h0F);
    check_all("R5");
  endtask

  task automatic t_rsvd();
    send(4'd11, 12'hFFF, 16);
    load();
    check_all("R7");
  endtask

  task automatic t_count();
    send(4'd1, 12'h777, 15);
    load();
    check_all("R8");
    send(4'd1, 12'h777, 17);
    send(4'd8, 12'h010, 17);
    load();
    check_all("R8");
    send(4'd1, 12'h123, 16);
    load();
    chk("R8", "ch1 after discard", 32'(dac_o[DW +: DW]), 32'h123);
  endtask

  task automatic t_tc();
    send(4'd8, 12'h001, 16);
    send(4'd5, 12'h123, 16);
    load();
    chk("R9", "ch5", 32'(dac_o[5*DW +: DW]), 32'h923);
    check_all("R9");
    send(4'd8, 12'h000, 16);
    load();
    chk("R9", "ch5 binary", 32'(dac_o[5*DW +: DW]), 32'h123);
  endtask

  task automatic t_pd();
    send(4'd9, 12'h020, 16);
    chk("R11", "pd", 32'(pd_o), 32'h0C);
    chk("R11", "ch2", 32'(dac_o[2*DW +: DW]), 32'h0);
    check_all("R11");
    send(4'd9, 12'h000, 16);
    chk("R12", "ch2 back", 32'(dac_o[2*DW +: DW]), 32'(outm[2]));
    check_all("R12");
    send(4'd8, 12'h010, 16);
    chk("R10", "pd", 32'(pd_o), 32'hFF);
    chk("R10", "dac", 32'(dac_o == '0), 32'h1);
    check_all("R10");
    send(4'd8, 12'h000, 16);
    check_all("R12");
  endtask

  task automatic t_preset();
    send(4'd9, 12'h00F, 16);
    send(4'd10, 12'h000, 16);
    for (int k = 0; k < NCH; k++)
      chk("R6", $sformatf("ch%0d", k), 32'(dac_o[k*DW +: DW]), 32'h800);
    chk("R6", "ctrl1 kept", 32'(ctrl1_o), 32'h0F);
    load();
    check_all("R6");
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < NCH; k++) begin bufm[k] = '0; outm[k] = '0; end
    c0m = '0;
    c1m = '0;
    cyc(3);
    rst_ni = 1'b1;
    cyc(2);
    t_reset();
    t_write();
    t_pair();
    t_ctrl();
    t_rsvd();
    t_count();
    t_tc();
    t_pd();
    t_preset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule